// File: doc/BRIEF.md
# Scaled Radix-2 Butterfly with Shift-Add Twiddle Rotation

This block performs one decimation-in-frequency radix-2 butterfly for a 64-point transform. It takes two complex fixed-point samples A and B and a twiddle index k. It returns the halved sum (A+B)/2 on one output and the halved, rotated difference (A−B)·W^k/2 on the other, where W^k = exp(−j2πk/64). Halving both outputs keeps the word width fixed from stage to stage without overflow. The surrounding sequencer supplies sample pairs and the index for each pass.

No general multiplier is used. Each twiddle product comes from a fixed network of shifts, adds and subtracts built from a signed-digit form of one constant. Only the constants of the first octant, angle indices 0 to 8, are wired in. Two banks hold them: one holds the cosine side and one the sine side. A quadrant step (W^(k+16) = −j·W^k) and an octant reflection (indices 9 to 15 reuse index 16−k with the cosine and sine roles swapped) map them onto all 32 twiddles. Operands arrive on a valid/ready handshake, and the result is held in a register that drives the outputs.

Top module: `radix2_bfly_scaled`

## Requirements
- R1: One clock after acceptance, x_re and x_im equal floor((A+B)/2) per component, computed without loss at 17 bits.
- R2: With d = A − B, C and S the twiddle constants for tw_k, y_re = clamp(floor((d_re·C + d_im·S)/2^15)) and y_im = clamp(floor((d_im·C − d_re·S)/2^15)).
- R3: tw_k is a 5-bit unsigned index 0..31. The constants are C = sign·round(|cos(2πk/64)|·2^14) and S = sign·round(|sin(2πk/64)|·2^14), each carrying the sign of the exact value. Indices 9..15 and 16..31 must give the same constants as a direct table would.
- R4: For tw_k = 0 the lower output is floor(d_re/2), floor(d_im/2), including odd negative differences.
- R5: For tw_k = 16 the lower output is floor(d_im/2) on the real part and floor(−d_re/2) on the imaginary part.
- R6: A lower-output value above 32767 gives 32767, and a value below −32768 gives −32768.
- R7: in_ready is high exactly when out of reset and either out_valid is low or out_ready is high. An input accepted on an edge (in_valid and in_ready) raises out_valid on that edge. out_valid falls after an edge with out_ready high and no acceptance.
- R8: While out_valid is high and out_ready is low, out_valid and all four result outputs stay unchanged.
- R9: While rst_n is low, out_valid and in_ready are low. in_ready stays low for the first edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| in_valid | input | 1 | Operands and index are presented |
| in_ready | output | 1 | Block can take operands this cycle |
| a_re | input | 16 | Real part of A, two's complement |
| a_im | input | 16 | Imaginary part of A |
| b_re | input | 16 | Real part of B |
| b_im | input | 16 | Imaginary part of B |
| tw_k | input | 5 | Twiddle index 0..31 |
| out_valid | output | 1 | Result registers hold a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| x_re | output | 16 | Real part of (A+B)/2 |
| x_im | output | 16 | Imaginary part of (A+B)/2 |
| y_re | output | 16 | Real part of (A−B)·W^k/2 |
| y_im | output | 16 | Imaginary part of (A−B)·W^k/2 |

## Verification
The properties assume that operands and index matter only on the edge where in_valid and in_ready are both high. They sample the inputs at that edge through $past, so they assume nothing about input stability at other times. They also assume that rst_n stays low long enough for the synchronizer to clear. The stimulus changes every input on every cycle, presents arbitrary full-range values so that the clamp is exercised, and toggles out_ready at random to create stalls. Directed cases sweep all 32 indices and hit the odd-negative rounding and both clamp limits.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  localparam int TW_FRAC  = 14;            // fraction bits of the constants
  localparam int TW_QTR   = 16;            // index of a quarter turn
  localparam int TW_OCT   = TW_QTR / 2;    // index of an eighth turn
  localparam int CSD_W    = TW_FRAC + 2;   // digit positions in a recoded constant

  // Magnitude of cos(2*pi*i/64) in Q14, i = 0..16 (first quadrant).
  function automatic int tw_mag(input int i);
    case (i)
      0:  return 16384;
      1:  return 16305;
      2:  return 16069;
      3:  return 15679;
      4:  return 15137;
      5:  return 14449;
      6:  return 13623;
      7:  return 12665;
      8:  return 11585;
      9:  return 10394;
      10: return 9102;
      11: return 7723;
      12: return 6270;
      13: return 4756;
      14: return 3196;
      15: return 1606;
      default: return 0;
    endcase
  endfunction

  // Canonical signed-digit recoding: returns the +1 digits or the -1 digits.
  function automatic logic [CSD_W-1:0] csd_mask(input int value, input bit want_neg);
    int x;
    int d;
    logic [CSD_W-1:0] pos;
    logic [CSD_W-1:0] neg;
    x   = value;
    pos = '0;
    neg = '0;
    for (int b = 0; b < CSD_W; b++) begin
      if ((x % 2) != 0) begin
        d = 2 - (x % 4);
        if (d == 1) pos[b] = 1'b1;
        else        neg[b] = 1'b1;
        x = x - d;
      end
      x = x / 2;
    end
    return want_neg ? neg : pos;
  endfunction

endpackage

// File: rtl/bfly_cmul.sv
module bfly_cmul
  import bfly_pkg::*;
#(
  parameter int XW   = 17,
  parameter int PW   = 33,
  parameter int COEF = 0
) (
  input  logic signed [XW-1:0] x,
  output logic signed [PW-1:0] p
);

  localparam logic [CSD_W-1:0] ADD_M = csd_mask(COEF, 1'b0);
  localparam logic [CSD_W-1:0] SUB_M = csd_mask(COEF, 1'b1);

  logic signed [PW-1:0] xe;

  assign xe = {{(PW-XW){x[XW-1]}}, x};

  // Shift-add network; the masks are constants so only the set digits cost adders.
  always_comb begin
    p = '0;
    for (int b = 0; b < CSD_W; b++) begin
      if (ADD_M[b]) p = p + (xe <<< b);
      if (SUB_M[b]) p = p - (xe <<< b);
    end
  end

endmodule

// File: rtl/bfly_coef_bank.sv
module bfly_coef_bank
  import bfly_pkg::*;
#(
  parameter int XW     = 17,
  parameter int PW     = 33,
  parameter int SELW   = 4,
  parameter int MIRROR = 0   // 0: cosine side (i), 1: sine side (16-i)
) (
  input  logic signed [XW-1:0]   x,
  input  logic        [SELW-1:0] sel,
  output logic signed [PW-1:0]   p
);

  localparam int NTAP = TW_OCT + 1;

  logic signed [PW-1:0] tap [NTAP];

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam int IDX = (MIRROR != 0) ? (TW_QTR - i) : i;
    bfly_cmul #(.XW(XW), .PW(PW), .COEF(tw_mag(IDX))) u_mul (
      .x (x),
      .p (tap[i])
    );
  end

  always_comb begin
    p = '0;
    for (int i = 0; i < NTAP; i++) begin
      if (sel == SELW'(i)) p = tap[i];
    end
  end

endmodule

// File: rtl/bfly_twiddle_rot.sv
module bfly_twiddle_rot
  import bfly_pkg::*;
#(
  parameter int DW   = 16,
  parameter int KW   = 5,
  parameter int SELW = 4
) (
  input  logic signed [DW:0]   dr,
  input  logic signed [DW:0]   di,
  input  logic        [KW-1:0] k,
  output logic signed [DW-1:0] yr,
  output logic signed [DW-1:0] yi
);

  localparam int XW = DW + 1;
  localparam int PW = XW + CSD_W;
  localparam int AW = PW + 1;
  localparam int SH = TW_FRAC + 1;
  localparam logic signed [AW-1:0] SAT_HI = AW'((2 ** (DW - 1)) - 1);
  localparam logic signed [AW-1:0] SAT_LO = ~SAT_HI;

  logic            quad;
  logic [KW-2:0]   r;
  logic            refl;
  logic [KW-1:0]   m_w;
  logic [SELW-1:0] m;

  logic signed [PW-1:0] p_rc, p_rs, p_ic, p_is;
  logic signed [AW-1:0] rc, rs, ic, is_;
  logic signed [AW-1:0] acc_re, acc_im, sh_re, sh_im;

  // Index folding: quadrant bit, then octant reflection onto 0..8.
  assign quad = k[KW-1];
  assign r    = k[KW-2:0];
  assign refl = (r > (KW-1)'(TW_OCT));
  assign m_w  = refl ? (KW'(TW_QTR) - {1'b0, r}) : {1'b0, r};
  assign m    = m_w[SELW-1:0];

  bfly_coef_bank #(.XW(XW), .PW(PW), .SELW(SELW), .MIRROR(0)) u_rc (.x(dr), .sel(m), .p(p_rc));
  bfly_coef_bank #(.XW(XW), .PW(PW), .SELW(SELW), .MIRROR(1)) u_rs (.x(dr), .sel(m), .p(p_rs));
  bfly_coef_bank #(.XW(XW), .PW(PW), .SELW(SELW), .MIRROR(0)) u_ic (.x(di), .sel(m), .p(p_ic));
  bfly_coef_bank #(.XW(XW), .PW(PW), .SELW(SELW), .MIRROR(1)) u_is (.x(di), .sel(m), .p(p_is));

  function automatic logic signed [DW-1:0] clamp(input logic signed [AW-1:0] v);
    if (v > SAT_HI)      return SAT_HI[DW-1:0];
    else if (v < SAT_LO) return SAT_LO[DW-1:0];
    else                 return v[DW-1:0];
  endfunction

  always_comb begin
    // products with the first-quadrant cosine/sine after reflection
    rc  = AW'(refl ? p_rs : p_rc);
    rs  = AW'(refl ? p_rc : p_rs);
    ic  = AW'(refl ? p_is : p_ic);
    is_ = AW'(refl ? p_ic : p_is);
    if (!quad) begin
      acc_re = rc + is_;
      acc_im = ic - rs;
    end else begin
      acc_re = ic - rs;
      acc_im = -is_ - rc;
    end
    sh_re = acc_re >>> SH;
    sh_im = acc_im >>> SH;
    yr    = clamp(sh_re);
    yi    = clamp(sh_im);
  end

endmodule

// File: rtl/radix2_bfly_scaled.sv
module radix2_bfly_scaled #(
  parameter int DW = 16,
  parameter int KW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic        [KW-1:0] tw_k,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] x_re,
  output logic signed [DW-1:0] x_im,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im
);

  localparam int SELW = KW - 1;

  logic [1:0] rsync_q;
  logic       rs_n;

  logic signed [DW:0]   s_re, s_im, d_re, d_im;
  logic signed [DW-1:0] xr_n, xi_n, yr_n, yi_n;
  logic signed [DW-1:0] xr_d, xi_d, yr_d, yi_d;
  logic signed [DW-1:0] xr_q, xi_q, yr_q, yi_q;
  logic                 ov_d, ov_q;
  logic                 accept;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rs_n = rsync_q[1];

  assign s_re = {a_re[DW-1], a_re} + {b_re[DW-1], b_re};
  assign s_im = {a_im[DW-1], a_im} + {b_im[DW-1], b_im};
  assign d_re = {a_re[DW-1], a_re} - {b_re[DW-1], b_re};
  assign d_im = {a_im[DW-1], a_im} - {b_im[DW-1], b_im};

  assign xr_n = DW'(s_re >>> 1);
  assign xi_n = DW'(s_im >>> 1);

  bfly_twiddle_rot #(.DW(DW), .KW(KW), .SELW(SELW)) u_rot (
    .dr (d_re),
    .di (d_im),
    .k  (tw_k),
    .yr (yr_n),
    .yi (yi_n)
  );

  assign in_ready = rs_n & (~ov_q | out_ready);
  assign accept   = in_valid & in_ready;

  always_comb begin
    ov_d = ov_q;
    xr_d = xr_q;
    xi_d = xi_q;
    yr_d = yr_q;
    yi_d = yi_q;
    if (accept) begin
      ov_d = 1'b1;
      xr_d = xr_n;
      xi_d = xi_n;
      yr_d = yr_n;
      yi_d = yi_n;
    end else if (out_ready) begin
      ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      ov_q <= 1'b0;
      xr_q <= '0;
      xi_q <= '0;
      yr_q <= '0;
      yi_q <= '0;
    end else begin
      ov_q <= ov_d;
      xr_q <= xr_d;
      xi_q <= xi_d;
      yr_q <= yr_d;
      yi_q <= yi_d;
    end
  end

  assign out_valid = ov_q;
  assign x_re      = xr_q;
  assign x_im      = xi_q;
  assign y_re      = yr_q;
  assign y_im      = yi_q;

endmodule

// File: rtl/bfly_chk.sv
module bfly_chk #(
  parameter int DW = 16,
  parameter int KW = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic signed [DW-1:0] a_re,
  input logic signed [DW-1:0] a_im,
  input logic signed [DW-1:0] b_re,
  input logic signed [DW-1:0] b_im,
  input logic        [KW-1:0] tw_k,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] x_re,
  input logic signed [DW-1:0] x_im,
  input logic signed [DW-1:0] y_re,
  input logic signed [DW-1:0] y_im
);

  logic                 take;
  logic signed [DW:0]   cs_re, cs_im, cd_re, cd_im, cn_re;
  logic signed [DW-1:0] hs_re, hs_im, hd_re, hd_im, hn_re;

  assign take  = in_valid && in_ready;
  assign cs_re = a_re + b_re;
  assign cs_im = a_im + b_im;
  assign cd_re = a_re - b_re;
  assign cd_im = a_im - b_im;
  assign cn_re = b_re - a_re;
  assign hs_re = DW'(cs_re >>> 1);
  assign hs_im = DW'(cs_im >>> 1);
  assign hd_re = DW'(cd_re >>> 1);
  assign hd_im = DW'(cd_im >>> 1);
  assign hn_re = DW'(cn_re >>> 1);

  // R9
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (!out_valid && !in_ready);
    end
  end

  // R7
  take_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R7
  full_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(x_re) && $stable(x_im)
                                   && $stable(y_re) && $stable(y_im)));

  // R1
  half_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (x_re == $past(hs_re) && x_im == $past(hs_im)));

  // R4
  zero_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tw_k == '0) |=> (y_re == $past(hd_re) && y_im == $past(hd_im)));

  // R5
  quarter_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tw_k == KW'(16)) |=> (y_re == $past(hd_im) && y_im == $past(hn_re)));

endmodule

bind radix2_bfly_scaled bfly_chk #(.DW(DW), .KW(KW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .a_re      (a_re),
  .a_im      (a_im),
  .b_re      (b_re),
  .b_im      (b_im),
  .tw_k      (tw_k),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .x_re      (x_re),
  .x_im      (x_im),
  .y_re      (y_re),
  .y_im      (y_im)
);

// File: tb/sim_radix2_bfly_scaled.sv
module sim_radix2_bfly_scaled;

  localparam int DW = 16;
  localparam int KW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic signed [DW-1:0] a_re, a_im, b_re, b_im;
  logic [KW-1:0] tw_k;
  logic signed [DW-1:0] x_re, x_im, y_re, y_im;

  always #10 clk = ~clk;

  radix2_bfly_scaled #(.DW(DW), .KW(KW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .tw_k(tw_k),
    .out_valid(out_valid), .out_ready(out_ready),
    .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural model state
  bit    m_ov = 0;
  bit    m_held = 0;
  int    m_xr, m_xi, m_yr, m_yi;
  string m_tag = "R2";

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int qcoef(input int k, input bit want_sin);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979 * real'(k) / 64.0;
    v = want_sin ? $sin(ang) : $cos(ang);
    if (v >= 0.0) return $rtoi(v * 16384.0 + 0.5);
    else          return -$rtoi(-v * 16384.0 + 0.5);
  endfunction

  function automatic int clamp16(input longint v, output bit hit);
    hit = 1'b0;
    if (v > 32767)  begin hit = 1'b1; return 32767;  end
    if (v < -32768) begin hit = 1'b1; return -32768; end
    return int'(v);
  endfunction

  task automatic model_load(input int ar, input int ai, input int br, input int bi, input int k);
    longint dr, di, c, s, re, im;
    bit h1, h2;
    m_xr = int'((longint'(ar) + br) >>> 1);
    m_xi = int'((longint'(ai) + bi) >>> 1);
    dr = longint'(ar) - br;
    di = longint'(ai) - bi;
    c  = qcoef(k, 1'b0);
    s  = qcoef(k, 1'b1);
    re = dr * c + di * s;
    im = di * c - dr * s;
    m_yr = clamp16(re >>> 15, h1);
    m_yi = clamp16(im >>> 15, h2);
    if (h1 || h2)             m_tag = "R6";
    else if (k == 0)          m_tag = "R4";
    else if (k == 16)         m_tag = "R5";
    else if ((k % 16) > 8 || k > 16) m_tag = "R3";
    else                      m_tag = "R2";
  endtask

  // one clock: compare registered outputs, drive, check ready, advance model
  task automatic cycle(input bit v, input int ar, input int ai, input int br,
                       input int bi, input int k, input bit ordy);
    bit exp_rdy;
    @(negedge clk);
    chk("R7 out_valid", int'(out_valid), int'(m_ov));
    if (m_ov) begin
      chk(m_held ? "R8 x_re" : "R1 x_re", int'(x_re), m_xr);
      chk(m_held ? "R8 x_im" : "R1 x_im", int'(x_im), m_xi);
      chk(m_held ? "R8 y_re" : {m_tag, " y_re"}, int'(y_re), m_yr);
      chk(m_held ? "R8 y_im" : {m_tag, " y_im"}, int'(y_im), m_yi);
    end
    in_valid  = v;
    a_re      = 16'(ar);
    a_im      = 16'(ai);
    b_re      = 16'(br);
    b_im      = 16'(bi);
    tw_k      = 5'(k);
    out_ready = ordy;
    #1;
    exp_rdy = !m_ov || ordy;
    chk("R7 in_ready", int'(in_ready), int'(exp_rdy));
    if (v && exp_rdy) begin
      model_load(ar, ai, br, bi, k);
      m_ov   = 1'b1;
      m_held = 1'b0;
    end else if (ordy) begin
      m_ov = 1'b0;
    end else if (m_ov) begin
      m_held = 1'b1;
    end
  endtask

  function automatic int rnd16();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    a_re = '0; a_im = '0; b_re = '0; b_im = '0; tw_k = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 out_valid in reset", int'(out_valid), 0);
    chk("R9 in_ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 in_ready one edge after release", int'(in_ready), 0);
    repeat (3) @(negedge clk);

    // R4: k=0 including odd negative difference
    cycle(1, 1000, -2000, 300, 500, 0, 1);
    cycle(1, 0, -1, 3, 2, 0, 1);
    // R5: quarter turn
    cycle(1, 1200, -700, -3301, 45, 16, 1);
    cycle(1, -32768, 32767, 32767, -32768, 16, 1);
    // R2: diagonal index
    cycle(1, 5000, 1234, -777, 2222, 8, 1);
    // R6: both clamp limits
    cycle(1, 32767, 32767, -32768, -32768, 8, 1);
    cycle(1, -32768, -32768, 32767, 32767, 8, 1);
    // R3: sweep every index
    for (int k = 0; k < 32; k++) cycle(1, 9000, -4100, -2500, 6100, k, 1);
    // R8: stall with changing inputs
    cycle(1, 111, 222, 333, 444, 5, 0);
    cycle(1, -900, 800, 70, -60, 13, 0);
    cycle(0, 1, 2, 3, 4, 7, 0);
    cycle(1, -900, 800, 70, -60, 27, 1);
    cycle(0, 0, 0, 0, 0, 0, 1);
    // random traffic with random back-pressure
    for (int i = 0; i < 4000; i++) begin
      cycle(($urandom_range(3) != 0), rnd16(), rnd16(), rnd16(), rnd16(),
            int'($urandom_range(31)), ($urandom_range(9) < 7));
    end
    // drain
    repeat (3) cycle(0, 0, 0, 0, 0, 0, 1);
    done = 1;
    summary();
    $finish;
  end

endmodule